// File: doc/BRIEF.md
# Four-bit universal shift register

This block is a small storage register whose next value is chosen by a two-bit operation code on every rising clock edge. The four operations are: keep the current contents, move every bit one place toward the low end with a serial bit entering at the top, rotate every bit one place toward the high end with the top bit wrapping into bit 0, and replace the whole word from a parallel input. It serves as a general-purpose staging register wherever a datapath needs a serial-to-parallel converter, a circular pattern generator or a plain loadable latch, all from one piece of hardware.

The design is structural. Each bit has its own 4-to-1 selector, which picks one of four candidate next values, and its own single-bit flip-flop, which stores the chosen value. The selector inputs are ordered so that the operation code indexes them directly. A synchronous active-low reset clears the word to zero and takes priority over every operation code.

Top module: `usr_shift_reg`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, `q_out` becomes 0 after that edge.
- R2: Operation code 2'b00 (hold) leaves `q_out` unchanged across the edge.
- R3: Operation code 2'b01 (shift right) sets `q_out[3]` to `ser_in` and each `q_out[i]` to the old `q_out[i+1]` for i from 2 down to 0.
- R4: Operation code 2'b10 (rotate left) sets each `q_out[i]` to the old `q_out[i-1]` for i from 3 down to 1, and `q_out[0]` to the old `q_out[3]`. `ser_in` has no effect in this operation.
- R5: Operation code 2'b11 (load) copies all four bits of `par_in` into `q_out`.
- R6: Reset overrides the operation code: a load with `rst_n` low still yields 0.
- R7: `ser_in` has no effect when the operation code is hold or load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes occur on its rising edge. |
| rst_n | input | 1 | Synchronous active-low reset, clears the register. |
| mode | input | 2 | Operation code: 00 hold, 01 shift right, 10 rotate left, 11 load. |
| ser_in | input | 1 | Serial bit that enters bit 3 on a right shift. |
| par_in | input | 4 | Parallel word for the load operation. |
| q_out | output | 4 | Current register contents. |

## Verification
Every result of this block falls due one rising edge after its inputs are applied, since the path from the inputs to `q_out` passes through exactly one flip-flop. The driver sets `mode`, `ser_in`, `par_in` and `rst_n` on a falling edge and queues the value the register must hold after the next rising edge. The monitor removes that value from the queue 1 ns after that rising edge and compares it with `q_out`. No check is ever taken on the edge itself or two edges late. The stimulus changes `ser_in` during hold, load and rotate, so that any leak of the serial bit shows up in the following comparison.

// File: rtl/usr_pkg.sv
// Package usr_pkg
// Purpose : shared operation codes and width for the universal shift register.
// Assumes : the operation code values equal the selector input indexes of
//           each per-bit multiplexer, so the code drives the select directly.
package usr_pkg;

    localparam int unsigned USR_MODE_W = 2;

    typedef enum logic [USR_MODE_W-1:0] {
        USR_HOLD   = 2'b00,
        USR_SHR    = 2'b01,
        USR_ROTL   = 2'b10,
        USR_LOAD   = 2'b11
    } usr_mode_e;

endpackage : usr_pkg

// File: rtl/usr_mux4.sv
// Module usr_mux4
// Purpose : combinational 4-to-1 selector for one bit.
// Assumes : sel is a two-bit index; every select value maps to one input,
//           so no value is held and no latch is inferred.
module usr_mux4 (
    input  logic [3:0] din,
    input  logic [1:0] sel,
    output logic       dout
);

    // Pick the data bit indexed by the select value.
    always_comb begin
        dout = din[sel];
    end

endmodule : usr_mux4

// File: rtl/usr_dff.sv
// Module usr_dff
// Purpose : single-bit storage element with synchronous active-low clear.
// Assumes : rst_n is sampled on the rising edge like data; clear wins over d.
module usr_dff (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Capture d on each rising edge, or clear when reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule : usr_dff

// File: rtl/usr_bit_slice.sv
// Module usr_bit_slice
// Purpose : one bit of the register: its selector feeding its flip-flop.
// Assumes : the four candidate next values arrive in operation-code order
//           (hold, shift-right source, rotate-left source, parallel bit).
module usr_bit_slice (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       own_q,
    input  logic       right_src,
    input  logic       left_src,
    input  logic       par_bit,
    output logic       q
);

    logic [3:0] cand;
    logic       next_bit;

    // Order the candidates so the operation code indexes them directly.
    always_comb begin
        cand[usr_pkg::USR_HOLD] = own_q;
        cand[usr_pkg::USR_SHR]  = right_src;
        cand[usr_pkg::USR_ROTL] = left_src;
        cand[usr_pkg::USR_LOAD] = par_bit;
    end

    usr_mux4 u_sel (
        .din  (cand),
        .sel  (mode),
        .dout (next_bit)
    );

    usr_dff u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_bit),
        .q     (q)
    );

endmodule : usr_bit_slice

// File: rtl/usr_shift_reg.sv
// Module usr_shift_reg
// Purpose : universal shift register with hold, shift right with serial
//           fill, rotate left and parallel load, one slice per bit.
// Assumes : WIDTH >= 2; reset is synchronous and active low.
module usr_shift_reg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] right_tap;
    logic [WIDTH-1:0] left_tap;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // Right-shift source: serial input at the top, upper neighbour elsewhere.
            if (i == TOP) begin : g_rtop
                assign right_tap[i] = ser_in;
            end else begin : g_rmid
                assign right_tap[i] = q_r[i+1];
            end

            // Rotate-left source: top bit wraps into bit 0, lower neighbour elsewhere.
            if (i == 0) begin : g_lbot
                assign left_tap[i] = q_r[TOP];
            end else begin : g_lmid
                assign left_tap[i] = q_r[i-1];
            end

            usr_bit_slice u_slice (
                .clk       (clk),
                .rst_n     (rst_n),
                .mode      (mode),
                .own_q     (q_r[i]),
                .right_src (right_tap[i]),
                .left_src  (left_tap[i]),
                .par_bit   (par_in[i]),
                .q         (q_r[i])
            );
        end
    endgenerate

    assign q_out = q_r;

endmodule : usr_shift_reg

// File: rtl/usr_shift_reg_chk.sv
// Module usr_shift_reg_chk
// Purpose : temporal checks on the ports of usr_shift_reg.
// Assumes : bound into every usr_shift_reg instance; rst_n low from time zero.
module usr_shift_reg_chk #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q_out
);

    // R1 R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q_out == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == 2'b00) |=> (q_out == $past(q_out)));

    // R3
    shift_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == 2'b01) |=> (q_out == {$past(ser_in), $past(q_out[WIDTH-1:1])}));

    // R4
    rotate_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == 2'b10) |=> (q_out == {$past(q_out[WIDTH-2:0]), $past(q_out[WIDTH-1])}));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == 2'b11) |=> (q_out == $past(par_in)));

endmodule : usr_shift_reg_chk

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .ser_in (ser_in),
    .par_in (par_in),
    .q_out  (q_out)
);

// File: tb/test_usr_shift_reg.sv
module test_usr_shift_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       ser_in = 1'b0;
    logic [3:0] par_in = 4'h0;
    logic [3:0] q_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [3:0] model = 4'h0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;  // 200 MHz

    usr_shift_reg i_usr_shift_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .ser_in (ser_in),
        .par_in (par_in),
        .q_out  (q_out)
    );

    // Driver: apply one cycle of stimulus on a falling edge and queue the expected result.
    task automatic drive(input logic rn, input logic [1:0] m, input logic s,
                         input logic [3:0] p, input string tag);
        @(negedge clk);
        rst_n  = rn;
        mode   = m;
        ser_in = s;
        par_in = p;
        if (!rn) model = 4'h0;
        else begin
            case (m)
                2'b00: model = model;
                2'b01: model = {s, model[3:1]};
                2'b10: model = {model[2:0], model[3]};
                default: model = p;
            endcase
        end
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare q_out 1 ns after each rising edge against the queued value.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (q_out !== e) begin
                    bad++;
                    $display("FAIL %s: q_out=%b expected=%b", t, q_out, e);
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        drive(1'b0, 2'b11, 1'b1, 4'hF, "R1 R6 reset beats load");
        drive(1'b0, 2'b00, 1'b0, 4'h0, "R1 reset state");
        drive(1'b1, 2'b11, 1'b0, 4'hA, "R5 load 1010");
        drive(1'b1, 2'b00, 1'b1, 4'h5, "R2 R7 hold, ser_in high");
        drive(1'b1, 2'b00, 1'b0, 4'h3, "R2 R7 hold, ser_in low");
        drive(1'b1, 2'b01, 1'b1, 4'h0, "R3 shift right fill 1");
        drive(1'b1, 2'b01, 1'b0, 4'h0, "R3 shift right fill 0");
        drive(1'b1, 2'b01, 1'b1, 4'h0, "R3 shift right fill 1");
        drive(1'b1, 2'b01, 1'b1, 4'h0, "R3 shift right fill 1");
        drive(1'b1, 2'b11, 1'b1, 4'h8, "R5 R7 load 1000, ser_in high");
        drive(1'b1, 2'b10, 1'b1, 4'h0, "R4 rotate left wraps top to bit 0");
        drive(1'b1, 2'b10, 1'b0, 4'h0, "R4 rotate left");
        drive(1'b1, 2'b10, 1'b1, 4'h0, "R4 rotate left ser_in ignored");
        drive(1'b1, 2'b10, 1'b0, 4'h0, "R4 rotate left back to 1000");
        drive(1'b1, 2'b11, 1'b0, 4'h6, "R5 load 0110");
        drive(1'b1, 2'b10, 1'b1, 4'h0, "R4 rotate 0110");
        drive(1'b1, 2'b10, 1'b1, 4'h0, "R4 rotate wrap 1100");
        drive(1'b1, 2'b01, 1'b0, 4'h0, "R3 shift right fill 0");
        drive(1'b1, 2'b11, 1'b0, 4'h1, "R5 load 0001");
        drive(1'b1, 2'b01, 1'b0, 4'h0, "R3 shift bit 0 out");
        drive(1'b1, 2'b11, 1'b1, 4'hF, "R5 load 1111");
        drive(1'b0, 2'b10, 1'b1, 4'h0, "R1 R6 reset mid-run beats rotate");
        drive(1'b1, 2'b00, 1'b1, 4'hF, "R2 hold after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule : test_usr_shift_reg